// File: doc/BRIEF.md
# Nested Task Return Unit

This unit carries out the return half of a hardware task switch. When an interrupt-return is issued and the nested-task bit in the current flags word is set, the unit walks the current task state block in memory. It stores the departing task's context into that block, then marks the departing task's descriptor as available again. Next it fetches the back-link selector from the block, looks up the outer task's descriptor and loads the outer task's saved context. Finally it reports the new task register contents together with the restored instruction pointer, flags and registers.

When the request is a plain return, or an interrupt-return with the nested-task bit clear, the unit does not touch memory. It raises a one-cycle indication that an ordinary stack-based return must be done instead. The back-link selector is loaded into the task register without any privilege comparison. Segment checks on the restored registers belong to other logic.

Memory is word addressed and reached through a single request/acknowledge port. A task state block holds the back-link selector at word 0 and the context from word 1 onward, in this order: instruction pointer, flags, then `CTX_WORDS` register words. A descriptor occupies two words at `table_base + 2*selector[15:3]`: word 0 is the task state block base and word 1 is the attribute word, whose busy flag is bit `BUSY_BIT`.

Top module: `tr_ret_unit`

## Requirements
- R1: A start with `is_iret`=0 raises `ret_stack` for exactly one cycle, in the cycle after start. It makes no memory access and sets `flags_o` to `flags_i` unchanged, nested-task bit included.
- R2: A start with `is_iret`=1 and bit `NT_BIT` (default 14) of `flags_i` clear behaves as R1. It gives a one-cycle `ret_stack`, no memory access and the same `flags_o` result.
- R3: A nested return first writes `CTX_WORDS`+2 words to `tr_base_i`+1 onward, ahead of any read. The words go in the order `ip_i`, `flags_i` with bit `NT_BIT` cleared, then `ctx_i` word 0 upward.
- R4: The unit then reads the departing task's attribute word at `table_base_i`+2*`tr_sel_i[15:3]`+1. It writes that word back with bit `BUSY_BIT` (default 1) cleared and every other bit kept. The outer task's descriptor is left unchanged.
- R5: The unit then reads word 0 of the current block. Bits [15:0] of that word, the back-link selector, appear on `tr_sel_o`. The requester-privilege bits and the descriptor's privilege field have no effect on this.
- R6: The unit then reads word 0 of the outer descriptor at `table_base_i`+2*link[15:3]. This word becomes `tr_base_o`.
- R7: Last, the unit reads `CTX_WORDS`+2 words from new base+1 onward in the R3 order. When `ret_done` pulses, `ip_o`, `flags_o` and `ctx_o` hold those words. A nested return makes exactly 2*(`CTX_WORDS`+2)+4 accesses.
- R8: `mem_req` stays high with address, write enable and write data stable until `mem_ack`. Each acknowledge completes one access.
- R9: `busy` is high from the cycle after an accepted nested start until `ret_done`. A start seen while `busy` is high is ignored. `tr_sel_o` and `tr_base_o` change only together with `ret_done`.
- R10: After reset `busy`, `mem_req`, `ret_stack` and `ret_done` are low, and `tr_sel_o` and `tr_base_o` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Return request |
| is_iret | input | 1 | 1: interrupt-return, 0: plain return |
| flags_i | input | 32 | Current flags word |
| ip_i | input | 32 | Current instruction pointer |
| ctx_i | input | 32*CTX_WORDS | Current register words, word 0 in the low bits |
| tr_sel_i | input | 16 | Current task register selector |
| tr_base_i | input | 32 | Current task state block base |
| table_base_i | input | 32 | Descriptor table base |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1: write, 0: read |
| mem_addr | output | 32 | Word address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access completes this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| busy | output | 1 | Nested return in progress |
| ret_stack | output | 1 | Ordinary stack return required |
| ret_done | output | 1 | Nested return complete |
| tr_sel_o | output | 16 | New task register selector |
| tr_base_o | output | 32 | New task state block base |
| ip_o | output | 32 | Restored instruction pointer |
| flags_o | output | 32 | Restored or passed-through flags |
| ctx_o | output | 32*CTX_WORDS | Restored register words |

## Verification
The bench builds the unit with `CTX_WORDS`=4, `NT_BIT`=14 and `BUSY_BIT`=1. With these values a nested return is a 16-access sequence, short enough to compare address by address and direction by direction. The memory model answers with zero or two wait cycles, which exercises the hold-until-acknowledge rule on both writes and reads. Back-link selectors with nonzero requester-privilege bits, an attribute word with many other bits set, and a start issued mid-sequence test the no-check load, the single-bit busy release and the busy lockout.

// File: rtl/tr_ret_pkg.sv
package tr_ret_pkg;
    localparam int ADDR_W         = 32;
    localparam int WORD_W         = 32;
    localparam int SEL_W          = 16;
    localparam int SEL_IDX_LSB    = 3;
    localparam int TSS_LINK_WORD  = 0;
    localparam int TSS_CTX_WORD   = 1;
    localparam int DESC_BASE_WORD = 0;
    localparam int DESC_ATTR_WORD = 1;
    localparam int DESC_WORDS     = 2;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [SEL_W-1:0]  sel_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SAVE,
        ST_RD_ATTR,
        ST_WR_ATTR,
        ST_RD_LINK,
        ST_RD_DESC,
        ST_LOAD
    } ret_state_e;

    typedef struct packed {
        sel_t  sel;
        addr_t tss_base;
        addr_t table_base;
    } task_ref_t;

    function automatic addr_t desc_addr(addr_t table_base, sel_t sel, int unsigned word);
        addr_t idx_off;
        idx_off = addr_t'(sel[SEL_W-1:SEL_IDX_LSB]) * addr_t'(DESC_WORDS);
        return table_base + idx_off + addr_t'(word);
    endfunction

    function automatic word_t clear_bit(word_t w, int unsigned pos);
        word_t m;
        m = word_t'(1) << pos;
        return w & ~m;
    endfunction
endpackage

// File: rtl/tr_ret_fsm.sv
module tr_ret_fsm
    import tr_ret_pkg::*;
#(
    parameter int SAVE_WORDS = 6,
    parameter int IDX_W      = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             is_iret,
    input  logic             nt_set,
    input  logic             mem_ack,
    output ret_state_e       state,
    output logic [IDX_W-1:0] idx,
    output logic             accept,
    output logic             take_stack,
    output logic             last_ack,
    output logic             ret_stack,
    output logic             ret_done
);
    logic at_last;

    always_comb begin
        accept     = (state == ST_IDLE) && start;
        take_stack = accept && !(is_iret && nt_set);
        at_last    = (idx == IDX_W'(SAVE_WORDS - 1));
        last_ack   = (state == ST_LOAD) && mem_ack && at_last;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            idx       <= '0;
            ret_stack <= 1'b0;
            ret_done  <= 1'b0;
        end else begin
            ret_stack <= take_stack;
            ret_done  <= last_ack;
            case (state)
                ST_IDLE: begin
                    if (accept && !take_stack) begin
                        state <= ST_SAVE;
                        idx   <= '0;
                    end
                end
                ST_SAVE: begin
                    if (mem_ack) begin
                        if (at_last) begin
                            state <= ST_RD_ATTR;
                            idx   <= '0;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                ST_RD_ATTR: if (mem_ack) state <= ST_WR_ATTR;
                ST_WR_ATTR: if (mem_ack) state <= ST_RD_LINK;
                ST_RD_LINK: if (mem_ack) state <= ST_RD_DESC;
                ST_RD_DESC: begin
                    if (mem_ack) begin
                        state <= ST_LOAD;
                        idx   <= '0;
                    end
                end
                ST_LOAD: begin
                    if (mem_ack) begin
                        if (at_last) begin
                            state <= ST_IDLE;
                            idx   <= '0;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/tr_ret_addr.sv
module tr_ret_addr
    import tr_ret_pkg::*;
#(
    parameter int SAVE_WORDS = 6,
    parameter int IDX_W      = 3,
    parameter int BUSY_BIT   = 1
) (
    input  ret_state_e                          state,
    input  logic [IDX_W-1:0]                    idx,
    input  task_ref_t                           cur,
    input  sel_t                                link_sel,
    input  addr_t                               new_base,
    input  word_t                               attr,
    input  logic [SAVE_WORDS-1:0][WORD_W-1:0]   save_words,
    output logic                                mem_req,
    output logic                                mem_we,
    output addr_t                               mem_addr,
    output word_t                               mem_wdata
);
    addr_t idx_off;

    always_comb begin
        idx_off   = addr_t'(idx);
        mem_req   = (state != ST_IDLE);
        mem_we    = (state == ST_SAVE) || (state == ST_WR_ATTR);
        mem_addr  = '0;
        mem_wdata = '0;
        case (state)
            ST_SAVE: begin
                mem_addr  = cur.tss_base + addr_t'(TSS_CTX_WORD) + idx_off;
                mem_wdata = save_words[idx];
            end
            ST_RD_ATTR: mem_addr = desc_addr(cur.table_base, cur.sel, DESC_ATTR_WORD);
            ST_WR_ATTR: begin
                mem_addr  = desc_addr(cur.table_base, cur.sel, DESC_ATTR_WORD);
                mem_wdata = clear_bit(attr, BUSY_BIT);
            end
            ST_RD_LINK: mem_addr = cur.tss_base + addr_t'(TSS_LINK_WORD);
            ST_RD_DESC: mem_addr = desc_addr(cur.table_base, link_sel, DESC_BASE_WORD);
            ST_LOAD:    mem_addr = new_base + addr_t'(TSS_CTX_WORD) + idx_off;
            default: begin
                mem_addr  = '0;
                mem_wdata = '0;
            end
        endcase
    end
endmodule

// File: rtl/tr_ret_ctx.sv
module tr_ret_ctx
    import tr_ret_pkg::*;
#(
    parameter int SAVE_WORDS = 6,
    parameter int IDX_W      = 3
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              load_en,
    input  logic [IDX_W-1:0]                  idx,
    input  word_t                             rdata,
    output logic [SAVE_WORDS-1:0][WORD_W-1:0] words
);
    for (genvar g = 0; g < SAVE_WORDS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                words[g] <= '0;
            end else if (load_en && (idx == IDX_W'(g))) begin
                words[g] <= rdata;
            end
        end
    end
endmodule

// File: rtl/tr_ret_unit.sv
module tr_ret_unit
    import tr_ret_pkg::*;
#(
    parameter int CTX_WORDS = 4,
    parameter int NT_BIT    = 14,
    parameter int BUSY_BIT  = 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        start,
    input  logic                        is_iret,
    input  logic [WORD_W-1:0]           flags_i,
    input  logic [WORD_W-1:0]           ip_i,
    input  logic [CTX_WORDS*WORD_W-1:0] ctx_i,
    input  logic [SEL_W-1:0]            tr_sel_i,
    input  logic [ADDR_W-1:0]           tr_base_i,
    input  logic [ADDR_W-1:0]           table_base_i,
    output logic                        mem_req,
    output logic                        mem_we,
    output logic [ADDR_W-1:0]           mem_addr,
    output logic [WORD_W-1:0]           mem_wdata,
    input  logic                        mem_ack,
    input  logic [WORD_W-1:0]           mem_rdata,
    output logic                        busy,
    output logic                        ret_stack,
    output logic                        ret_done,
    output logic [SEL_W-1:0]            tr_sel_o,
    output logic [ADDR_W-1:0]           tr_base_o,
    output logic [WORD_W-1:0]           ip_o,
    output logic [WORD_W-1:0]           flags_o,
    output logic [CTX_WORDS*WORD_W-1:0] ctx_o
);
    localparam int SAVE_WORDS = CTX_WORDS + 2;
    localparam int IDX_W      = $clog2(SAVE_WORDS);
    localparam int IP_SLOT    = 0;
    localparam int FLAG_SLOT  = 1;
    localparam int REG_SLOT   = 2;

    ret_state_e                        state;
    logic [IDX_W-1:0]                  idx;
    logic                              accept, take_stack, last_ack;
    task_ref_t                         cur_q;
    sel_t                              link_q;
    addr_t                             new_base_q;
    word_t                             attr_q;
    logic [SAVE_WORDS-1:0][WORD_W-1:0] save_q;
    logic [SAVE_WORDS-1:0][WORD_W-1:0] load_w;
    logic [SAVE_WORDS-1:0][WORD_W-1:0] snap;
    logic                              load_en;

    always_comb begin
        snap[IP_SLOT]   = ip_i;
        snap[FLAG_SLOT] = clear_bit(flags_i, NT_BIT);
        for (int k = 0; k < CTX_WORDS; k++) begin
            snap[REG_SLOT+k] = ctx_i[k*WORD_W +: WORD_W];
        end
        load_en = (state == ST_LOAD) && mem_ack;
        busy    = (state != ST_IDLE);
    end

    tr_ret_fsm #(.SAVE_WORDS(SAVE_WORDS), .IDX_W(IDX_W)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .is_iret    (is_iret),
        .nt_set     (flags_i[NT_BIT]),
        .mem_ack    (mem_ack),
        .state      (state),
        .idx        (idx),
        .accept     (accept),
        .take_stack (take_stack),
        .last_ack   (last_ack),
        .ret_stack  (ret_stack),
        .ret_done   (ret_done)
    );

    tr_ret_addr #(.SAVE_WORDS(SAVE_WORDS), .IDX_W(IDX_W), .BUSY_BIT(BUSY_BIT)) u_addr (
        .state      (state),
        .idx        (idx),
        .cur        (cur_q),
        .link_sel   (link_q),
        .new_base   (new_base_q),
        .attr       (attr_q),
        .save_words (save_q),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata)
    );

    tr_ret_ctx #(.SAVE_WORDS(SAVE_WORDS), .IDX_W(IDX_W)) u_ctx (
        .clk     (clk),
        .rst     (rst),
        .load_en (load_en),
        .idx     (idx),
        .rdata   (mem_rdata),
        .words   (load_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q      <= '0;
            save_q     <= '0;
            link_q     <= '0;
            new_base_q <= '0;
            attr_q     <= '0;
            tr_sel_o   <= '0;
            tr_base_o  <= '0;
            flags_o    <= '0;
        end else begin
            if (accept && !take_stack) begin
                cur_q.sel        <= tr_sel_i;
                cur_q.tss_base   <= tr_base_i;
                cur_q.table_base <= table_base_i;
                save_q           <= snap;
            end
            if (take_stack) flags_o <= flags_i;
            if (mem_ack && state == ST_RD_ATTR) attr_q <= mem_rdata;
            if (mem_ack && state == ST_RD_LINK) link_q <= mem_rdata[SEL_W-1:0];
            if (mem_ack && state == ST_RD_DESC) new_base_q <= mem_rdata;
            if (load_en && idx == IDX_W'(FLAG_SLOT)) flags_o <= mem_rdata;
            if (last_ack) begin
                tr_sel_o  <= link_q;
                tr_base_o <= new_base_q;
            end
        end
    end

    always_comb begin
        ip_o = load_w[IP_SLOT];
        for (int k = 0; k < CTX_WORDS; k++) begin
            ctx_o[k*WORD_W +: WORD_W] = load_w[REG_SLOT+k];
        end
    end
endmodule

// File: rtl/tr_ret_chk.sv
module tr_ret_chk
    import tr_ret_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        mem_req,
    input logic        mem_we,
    input logic        mem_ack,
    input addr_t       mem_addr,
    input word_t       mem_wdata,
    input logic        ret_stack,
    input logic        ret_done,
    input sel_t        tr_sel_o,
    input addr_t       tr_base_o
);
    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R9
    req_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy);

    // R1
    stack_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        ret_stack |-> (!busy && !mem_req));

    // R2
    stack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        ret_stack |=> !ret_stack);

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        ret_done |-> (!busy && !ret_stack));

    // R9
    tr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ret_done |-> ($stable(tr_sel_o) && $stable(tr_base_o)));
endmodule

bind tr_ret_unit tr_ret_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .ret_stack (ret_stack),
    .ret_done  (ret_done),
    .tr_sel_o  (tr_sel_o),
    .tr_base_o (tr_base_o)
);

// File: tb/tr_ret_unit_bench.sv
`timescale 1ns/1ps
module tr_ret_unit_bench;
    localparam int CW   = 4;
    localparam int NT   = 14;
    localparam int BB   = 1;
    localparam int SW   = CW + 2;
    localparam int GDT  = 32'h80;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic is_iret = 1'b0;
    logic [31:0] flags_i = '0, ip_i = '0;
    logic [CW*32-1:0] ctx_i = '0;
    logic [15:0] tr_sel_i = '0;
    logic [31:0] tr_base_i = '0, table_base_i = GDT;
    logic mem_req, mem_we, busy, ret_stack, ret_done;
    logic [31:0] mem_addr, mem_wdata;
    logic mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [15:0] tr_sel_o;
    logic [31:0] tr_base_o, ip_o, flags_o;
    logic [CW*32-1:0] ctx_o;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    logic [31:0] mem [0:255];
    logic [31:0] acc_addr [0:63];
    logic        acc_we [0:63];
    int n_acc = 0;
    int wait_gap = 0;
    int gap_cnt = 0;

    always #2.5 clk = ~clk;

    tr_ret_unit #(.CTX_WORDS(CW), .NT_BIT(NT), .BUSY_BIT(BB)) u_tr_ret_unit (
        .clk(clk), .rst(rst), .start(start), .is_iret(is_iret), .flags_i(flags_i),
        .ip_i(ip_i), .ctx_i(ctx_i), .tr_sel_i(tr_sel_i), .tr_base_i(tr_base_i),
        .table_base_i(table_base_i), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .busy(busy), .ret_stack(ret_stack), .ret_done(ret_done),
        .tr_sel_o(tr_sel_o), .tr_base_o(tr_base_o), .ip_o(ip_o), .flags_o(flags_o),
        .ctx_o(ctx_o)
    );

    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack = 1'b0;
        end else if (mem_req) begin
            if (gap_cnt < wait_gap) begin
                gap_cnt++;
            end else begin
                gap_cnt = 0;
                mem_ack = 1'b1;
                acc_addr[n_acc % 64] = mem_addr;
                acc_we[n_acc % 64] = mem_we;
                n_acc++;
                if (mem_we) mem[mem_addr[7:0]] = mem_wdata;
                else mem_rdata = mem[mem_addr[7:0]];
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run hung, actual cycles %0d expected below 100000", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 busy", 32'(busy), 0);
        chk("R10 mem_req", 32'(mem_req), 0);
        chk("R10 ret_stack", 32'(ret_stack), 0);
        chk("R10 ret_done", 32'(ret_done), 0);
        chk("R10 tr_sel_o", 32'(tr_sel_o), 0);
        chk("R10 tr_base_o", tr_base_o, 0);
    endtask

    task automatic t_flat(input string req, input logic iret, input logic [31:0] fl);
        int base_n;
        base_n = n_acc;
        flags_i = fl;
        is_iret = iret;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk({req, " ret_stack pulse"}, 32'(ret_stack), 1);
        chk({req, " flags_o passthrough"}, flags_o, fl);
        @(negedge clk);
        chk({req, " ret_stack one cycle"}, 32'(ret_stack), 0);
        repeat (4) @(negedge clk);
        chk({req, " no memory access"}, 32'(n_acc - base_n), 0);
        chk({req, " not busy"}, 32'(busy), 0);
    endtask

    task automatic run_nested(input logic [15:0] osel, input logic [31:0] obase,
                              input logic [31:0] link_word, input logic [31:0] nbase,
                              input int gap, input bit stray);
        int base_n, oi, ni, t;
        logic [31:0] oattr, nattr, exp_a [0:15];
        logic        exp_w [0:15];
        logic [31:0] save_w [0:SW-1];
        logic [31:0] outer_w [0:SW-1];
        oi = int'(osel[15:3]);
        ni = int'(link_word[15:3]);
        oattr = 32'hA5A5_00EB;
        nattr = 32'h0000_0089;
        mem[GDT + 2*oi] = obase;
        mem[GDT + 2*oi + 1] = oattr;
        mem[GDT + 2*ni] = nbase;
        mem[GDT + 2*ni + 1] = nattr;
        mem[obase] = link_word;
        for (int k = 0; k < SW; k++) begin
            outer_w[k] = {8'hC0, nbase[7:0], 8'h5A, 8'(k)};
            mem[nbase + 1 + k] = outer_w[k];
        end
        ip_i = {16'h1234, obase[15:0]};
        flags_i = 32'h0000_4AD7;
        for (int k = 0; k < CW; k++) ctx_i[k*32 +: 32] = {8'hE0, 8'(k), osel};
        save_w[0] = ip_i;
        save_w[1] = flags_i & ~(32'h1 << NT);
        for (int k = 0; k < CW; k++) save_w[2+k] = ctx_i[k*32 +: 32];
        for (int k = 0; k < SW; k++) begin
            exp_a[k] = obase + 1 + k;  exp_w[k] = 1'b1;
            exp_a[SW+4+k] = nbase + 1 + k;  exp_w[SW+4+k] = 1'b0;
        end
        exp_a[SW]   = GDT + 2*oi + 1; exp_w[SW]   = 1'b0;
        exp_a[SW+1] = GDT + 2*oi + 1; exp_w[SW+1] = 1'b1;
        exp_a[SW+2] = obase;          exp_w[SW+2] = 1'b0;
        exp_a[SW+3] = GDT + 2*ni;     exp_w[SW+3] = 1'b0;
        tr_sel_i = osel;
        tr_base_i = obase;
        wait_gap = gap;
        base_n = n_acc;
        is_iret = 1'b1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R9 busy after start", 32'(busy), 1);
        chk("R2 no ret_stack when nested", 32'(ret_stack), 0);
        if (stray) begin
            is_iret = 1'b0;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            is_iret = 1'b1;
            @(negedge clk);
            chk("R9 start ignored while busy", 32'(ret_stack), 0);
        end
        t = 0;
        while (!ret_done && t < 2000) begin
            @(negedge clk);
            t++;
        end
        chk("R7 ret_done seen", 32'(ret_done), 1);
        chk("R9 busy low at done", 32'(busy), 0);
        chk("R7 access count", 32'(n_acc - base_n), 32'(2*SW + 4));
        for (int k = 0; k < 2*SW + 4; k++) begin
            chk("R3 R4 R5 R6 R7 access address", acc_addr[(base_n + k) % 64], exp_a[k]);
            chk("R3 R4 R5 R6 R7 access direction", 32'(acc_we[(base_n + k) % 64]), 32'(exp_w[k]));
        end
        for (int k = 0; k < SW; k++) chk("R3 saved word", mem[obase + 1 + k], save_w[k]);
        chk("R3 saved flags nested bit clear", 32'(mem[obase + 2][NT]), 0);
        chk("R4 departing attr busy cleared", mem[GDT + 2*oi + 1], oattr & ~(32'h1 << BB));
        chk("R4 outer attr untouched", mem[GDT + 2*ni + 1], nattr);
        chk("R5 tr_sel_o from link", 32'(tr_sel_o), 32'(link_word[15:0]));
        chk("R6 tr_base_o from descriptor", tr_base_o, nbase);
        chk("R7 ip_o", ip_o, outer_w[0]);
        chk("R7 flags_o", flags_o, outer_w[1]);
        for (int k = 0; k < CW; k++) chk("R7 ctx_o word", ctx_o[k*32 +: 32], outer_w[2+k]);
        @(negedge clk);
        chk("R7 ret_done one cycle", 32'(ret_done), 0);
        chk("R9 tr_sel_o held", 32'(tr_sel_o), 32'(link_word[15:0]));
        wait_gap = 0;
    endtask

    initial begin
        for (int a = 0; a < 256; a++) mem[a] = '0;
        t_reset();
        t_flat("R1 plain return nested set", 1'b0, 32'h0000_4202);
        t_flat("R2 iret nested clear", 1'b1, 32'h0000_0246);
        run_nested(16'h0018, 32'h10, 32'hDEAD_002B, 32'h40, 0, 1'b0);
        run_nested(16'h0013, 32'h20, 32'h0000_003A, 32'h60, 2, 1'b1);
        t_flat("R1 plain return after nested", 1'b0, 32'hFFFF_FFFF);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule